// File: doc/BRIEF.md
# Embedded Audio Lock Detector

This block watches a 10-bit parallel video word stream and decides whether the embedded audio in it runs in step with the video. Audio extraction further down the chip may start only once that is settled. The block stays idle until a separate flag reports that the incoming video matches the selected standard.

It then applies one of two criteria, chosen by a plain control pin:
- **Sample count.** It adds up the audio samples carried by matching audio data packets over a window of whole frames, and compares the total with an expected figure.
- **Control packet.** It looks for a single audio control packet with the programmed identifier, placed at a programmed line and word.

Once lock is set it ignores later variation in the sample count. It drops lock only after a full window passes with no relevant packet. Line and word positions, frame starts, the expected sample total and the window length all come in on pins, so the same engine serves both 525-line and 625-line timing.

The video input is a monitored stream with a valid qualifier and no ready signal. The block never applies back-pressure and never stalls the source. A word is consumed on every rising clock edge at which `vid_valid` is high. Words presented while `vid_valid` is low carry no meaning and are dropped. The pins `vid_line`, `vid_pos` and `frame_start` are qualified by the same `vid_valid`.

Top module: `audio_lock_detect`

## Requirements
- R1: After reset, `lock_o` and `demux_en` are low.
- R2: When `std_verified` is low, `lock_o` is low from the next clock edge, and window counting restarts from scratch once the flag returns high.
- R3: With `method_sel` low, the block arms on the first frame start after verification. `win_frames` later frame starts close a window (0 is treated as 1). `lock_o` rises on the edge that closes the window if, and only if, the window's sample total equals `exp_samples`.
- R4: With `method_sel` high, `lock_o` rises one clock after a complete packet whose DID low byte equals `{CTL_DID_HI, did_sel}` and whose first flag word (0x000) came with `vid_line == ctrl_line` and `vid_pos == ctrl_pos`.
- R5: With `method_sel` high, a stream without a matching, correctly placed control packet never sets lock. This holds even if audio data packets are present.
- R6: Once set, lock stays high across windows whose sample total is above or below `exp_samples`, as long as each window contains at least one relevant packet.
- R7: At the end of a window that contained no audio data packet and no matching control packet, `lock_o` clears on that closing edge.
- R8: `demux_en` is high exactly while `lock_o` is high and `std_verified` is high.
- R9: A packet is recognised only after the flag words 0x000, 0x3FF, 0x3FF, followed by DID, secondary DID, data count (low byte), that many user words, and a checksum. Any other flag sequence is ignored. Only packets whose DID low byte is `{AUD_DID_HI, did_sel}` add samples, and each adds data count >> 2 samples.
- R10: Words with `vid_valid` low do not advance packet parsing or frame counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_valid | input | 1 | Qualifies the video word and its position pins |
| vid_word | input | 10 | Video data word |
| vid_line | input | 11 | Line number of the current word |
| vid_pos | input | 12 | Word position of the current word within its line |
| frame_start | input | 1 | Marks the current valid word as the first of a frame |
| std_verified | input | 1 | Video standard has been confirmed |
| method_sel | input | 1 | 0: sample-count lock, 1: control-packet lock |
| did_sel | input | 4 | Low nibble of the audio and control DIDs |
| ctrl_line | input | 11 | Expected line of the control packet |
| ctrl_pos | input | 12 | Expected word position of the control packet's first flag word |
| exp_samples | input | 16 | Sample total expected per window |
| win_frames | input | 4 | Frames per counting window |
| lock_o | output | 1 | Audio locked to video |
| demux_en | output | 1 | Audio demultiplexing may run |

## Verification
The count criterion is swept over window lengths of one to three frames. In each case the sample total is set one below, equal to, and one above the expected figure, so that only exact equality at the window boundary produces lock and a check of the state before the boundary catches any early decision. Decoy packets are mixed into those windows: one with a foreign DID, one sent with `vid_valid` low, and one with a zero data count. Each decoy would change the total by a known amount if it were wrongly counted. The control criterion is tried with a packet on the wrong word, on the wrong line, with the wrong DID, and with a broken flag sequence, and then with a correct one, which tells the position and identifier filters apart from the parser. Sticky behaviour is shown by windows with surplus and deficit totals after lock, and release by an empty window.

// File: rtl/ald_pkg.sv
package ald_pkg;
  typedef enum logic [2:0] {
    PS_IDLE, PS_FLAG1, PS_FLAG2, PS_DID, PS_SDID, PS_DC, PS_UDW, PS_CSUM
  } parse_state_t;

  typedef struct packed {
    logic [7:0] did;
    logic [7:0] dcount;
  } anc_hdr_t;
endpackage

// File: rtl/ald_anc_parser.sv
module ald_anc_parser
  import ald_pkg::*;
#(
  parameter int DW     = 10,
  parameter int LINE_W = 11,
  parameter int POS_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_valid,
  input  logic [DW-1:0]     vid_word,
  input  logic [LINE_W-1:0] vid_line,
  input  logic [POS_W-1:0]  vid_pos,
  output logic              pkt_done,
  output anc_hdr_t          pkt_hdr,
  output logic [LINE_W-1:0] pkt_line,
  output logic [POS_W-1:0]  pkt_pos
);
  localparam logic [DW-1:0] WORD_ZERO = '0;
  localparam logic [DW-1:0] WORD_ONES = '1;

  parse_state_t state;
  logic [7:0]   words_left;
  anc_hdr_t     hdr_q;
  logic [LINE_W-1:0] line_q;
  logic [POS_W-1:0]  pos_q;

  assign pkt_hdr  = hdr_q;
  assign pkt_line = line_q;
  assign pkt_pos  = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PS_IDLE;
      words_left <= '0;
      hdr_q      <= '0;
      line_q     <= '0;
      pos_q      <= '0;
      pkt_done   <= 1'b0;
    end else begin
      pkt_done <= 1'b0;
      if (vid_valid) begin
        unique case (state)
          PS_IDLE: if (vid_word == WORD_ZERO) begin
            state  <= PS_FLAG1;
            line_q <= vid_line;
            pos_q  <= vid_pos;
          end
          PS_FLAG1, PS_FLAG2: begin
            if (vid_word == WORD_ONES) begin
              state <= (state == PS_FLAG1) ? PS_FLAG2 : PS_DID;
            end else if (vid_word == WORD_ZERO) begin
              state  <= PS_FLAG1;
              line_q <= vid_line;
              pos_q  <= vid_pos;
            end else begin
              state <= PS_IDLE;
            end
          end
          PS_DID: begin
            hdr_q.did <= vid_word[7:0];
            state     <= PS_SDID;
          end
          PS_SDID: state <= PS_DC;
          PS_DC: begin
            hdr_q.dcount <= vid_word[7:0];
            words_left   <= vid_word[7:0];
            state        <= (vid_word[7:0] == 8'd0) ? PS_CSUM : PS_UDW;
          end
          PS_UDW: begin
            words_left <= words_left - 8'd1;
            if (words_left == 8'd1) state <= PS_CSUM;
          end
          PS_CSUM: begin
            pkt_done <= 1'b1;
            state    <= PS_IDLE;
          end
          default: state <= PS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ald_frame_window.sv
module ald_frame_window #(
  parameter int CW = 16,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          sof,
  input  logic [FW-1:0] win_frames,
  input  logic          add_valid,
  input  logic [7:0]    add_amt,
  input  logic          hit,
  output logic          win_end,
  output logic [CW-1:0] win_count,
  output logic          win_seen
);
  localparam logic [CW:0] SUM_MAX = {1'b0, {CW{1'b1}}};

  logic          armed;
  logic [FW-1:0] frm_cnt;
  logic [CW:0]   sum_ext;

  assign win_end = enable && armed && sof &&
                   (({1'b0, frm_cnt} + (FW+1)'(1)) >= {1'b0, win_frames});
  assign sum_ext = {1'b0, win_count} + (CW+1)'(add_amt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      frm_cnt   <= '0;
      win_count <= '0;
      win_seen  <= 1'b0;
    end else if (!enable) begin
      armed     <= 1'b0;
      frm_cnt   <= '0;
      win_count <= '0;
      win_seen  <= 1'b0;
    end else if (sof && !armed) begin
      armed     <= 1'b1;
      frm_cnt   <= '0;
      win_count <= '0;
      win_seen  <= 1'b0;
    end else if (win_end) begin
      frm_cnt   <= '0;
      win_count <= add_valid ? CW'(add_amt) : '0;
      win_seen  <= hit;
    end else if (armed) begin
      if (sof) frm_cnt <= frm_cnt + FW'(1);
      if (add_valid) win_count <= (sum_ext > SUM_MAX) ? SUM_MAX[CW-1:0] : sum_ext[CW-1:0];
      if (hit) win_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/ald_lock_ctrl.sv
module ald_lock_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          method_sel,
  input  logic          win_end,
  input  logic [CW-1:0] win_count,
  input  logic          win_seen,
  input  logic [CW-1:0] exp_samples,
  input  logic          ctrl_hit,
  output logic          locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
    end else if (!enable) begin
      locked <= 1'b0;
    end else if (locked) begin
      if (win_end && !win_seen) locked <= 1'b0;
    end else if (!method_sel) begin
      if (win_end && (win_count == exp_samples)) locked <= 1'b1;
    end else if (ctrl_hit) begin
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/audio_lock_detect.sv
module audio_lock_detect
  import ald_pkg::*;
#(
  parameter int DW     = 10,
  parameter int LINE_W = 11,
  parameter int POS_W  = 12,
  parameter int CW     = 16,
  parameter int FW     = 4,
  parameter logic [3:0] AUD_DID_HI = 4'hE,
  parameter logic [3:0] CTL_DID_HI = 4'hD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_valid,
  input  logic [DW-1:0]     vid_word,
  input  logic [LINE_W-1:0] vid_line,
  input  logic [POS_W-1:0]  vid_pos,
  input  logic              frame_start,
  input  logic              std_verified,
  input  logic              method_sel,
  input  logic [3:0]        did_sel,
  input  logic [LINE_W-1:0] ctrl_line,
  input  logic [POS_W-1:0]  ctrl_pos,
  input  logic [CW-1:0]     exp_samples,
  input  logic [FW-1:0]     win_frames,
  output logic              lock_o,
  output logic              demux_en
);
  localparam int SMP_SHIFT = 2;

  logic              pkt_done;
  anc_hdr_t          pkt_hdr;
  logic [LINE_W-1:0] pkt_line;
  logic [POS_W-1:0]  pkt_pos;
  logic              aud_hit, ctrl_hit, win_end, win_seen;
  logic [CW-1:0]     win_count;
  logic [7:0]        smp_amt;

  ald_anc_parser #(.DW(DW), .LINE_W(LINE_W), .POS_W(POS_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_word(vid_word),
    .vid_line(vid_line), .vid_pos(vid_pos), .pkt_done(pkt_done),
    .pkt_hdr(pkt_hdr), .pkt_line(pkt_line), .pkt_pos(pkt_pos)
  );

  assign aud_hit  = pkt_done && (pkt_hdr.did == {AUD_DID_HI, did_sel});
  assign ctrl_hit = pkt_done && (pkt_hdr.did == {CTL_DID_HI, did_sel}) &&
                    (pkt_line == ctrl_line) && (pkt_pos == ctrl_pos);
  assign smp_amt  = pkt_hdr.dcount >> SMP_SHIFT;

  ald_frame_window #(.CW(CW), .FW(FW)) u_win (
    .clk(clk), .rst_n(rst_n), .enable(std_verified),
    .sof(vid_valid && frame_start), .win_frames(win_frames),
    .add_valid(aud_hit), .add_amt(smp_amt), .hit(aud_hit || ctrl_hit),
    .win_end(win_end), .win_count(win_count), .win_seen(win_seen)
  );

  ald_lock_ctrl #(.CW(CW)) u_lock (
    .clk(clk), .rst_n(rst_n), .enable(std_verified), .method_sel(method_sel),
    .win_end(win_end), .win_count(win_count), .win_seen(win_seen),
    .exp_samples(exp_samples), .ctrl_hit(ctrl_hit), .locked(lock_o)
  );

  assign demux_en = lock_o && std_verified;
endmodule

// File: rtl/ald_chk.sv
module ald_chk (
  input logic clk,
  input logic rst_n,
  input logic std_verified,
  input logic method_sel,
  input logic lock_o,
  input logic demux_en,
  input logic win_end,
  input logic pkt_done
);
  // R2
  unverified_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !std_verified |=> !lock_o);

  // R3
  count_lock_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lock_o) && !$past(method_sel)) |-> $past(win_end));

  // R4
  ctrl_lock_after_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lock_o) && $past(method_sel)) |-> $past(pkt_done));

  // R6
  release_only_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> ($past(win_end) || !$past(std_verified)));

  // R8
  demux_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && std_verified) |-> demux_en);

  // R9
  packet_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);
endmodule

bind audio_lock_detect ald_chk u_ald_chk (
  .clk(clk), .rst_n(rst_n), .std_verified(std_verified), .method_sel(method_sel),
  .lock_o(lock_o), .demux_en(demux_en), .win_end(win_end), .pkt_done(pkt_done)
);

// File: tb/audio_lock_detect_tb.sv
`timescale 1ns/1ps
module audio_lock_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vid_valid = 1'b0;
  logic [9:0]  vid_word = '0;
  logic [10:0] vid_line = '0;
  logic [11:0] vid_pos = '0;
  logic        frame_start = 1'b0;
  logic        std_verified = 1'b0;
  logic        method_sel = 1'b0;
  logic [3:0]  did_sel = 4'h7;
  logic [10:0] ctrl_line = 11'd9;
  logic [11:0] ctrl_pos = 12'd20;
  logic [15:0] exp_samples = '0;
  logic [3:0]  win_frames = 4'd1;
  logic        lock_o, demux_en;

  int tests = 0, fails = 0;
  bit done = 0;

  localparam logic [9:0] AUD_DID  = 10'h2E7;
  localparam logic [9:0] CTL_DID  = 10'h1D7;
  localparam logic [9:0] BAD_DID  = 10'h2E3;

  always #2 clk = ~clk;

  audio_lock_detect dut_i (
    .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_word(vid_word),
    .vid_line(vid_line), .vid_pos(vid_pos), .frame_start(frame_start),
    .std_verified(std_verified), .method_sel(method_sel), .did_sel(did_sel),
    .ctrl_line(ctrl_line), .ctrl_pos(ctrl_pos), .exp_samples(exp_samples),
    .win_frames(win_frames), .lock_o(lock_o), .demux_en(demux_en)
  );

  task automatic check(input string req, input logic act, input logic exp_v);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp_v);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vid_valid = 1'b0;
      frame_start = 1'b0;
    end
  endtask

  task automatic send_word(input logic [9:0] w, input logic [10:0] ln,
                           input logic [11:0] ps, input logic sof, input logic vld);
    @(negedge clk);
    vid_valid = vld; vid_word = w; vid_line = ln; vid_pos = ps; frame_start = sof;
  endtask

  task automatic send_pkt(input logic [9:0] did, input int dc, input logic [10:0] ln,
                          input logic [11:0] ps, input logic vld);
    send_word(10'h000, ln, ps, 0, vld);
    send_word(10'h3FF, ln, ps + 12'd1, 0, vld);
    send_word(10'h3FF, ln, ps + 12'd2, 0, vld);
    send_word(did, ln, ps + 12'd3, 0, vld);
    send_word(10'h101, ln, ps + 12'd4, 0, vld);
    send_word(10'(dc), ln, ps + 12'd5, 0, vld);
    for (int k = 0; k < dc; k++) send_word(10'h200 + 10'(k), ln, ps + 12'(6 + k), 0, vld);
    send_word(10'h1AA, ln, ps + 12'(6 + dc), 0, vld);
    idle(3);
  endtask

  task automatic frame_edge();
    send_word(10'h200, 11'd1, 12'd0, 1, 1);
    idle(2);
  endtask

  task automatic audio_samples(input int n);
    for (int i = 0; i < n; i++) send_pkt(AUD_DID, 4, 11'd12, 12'd40, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 lock after reset", lock_o, 0);
    check("R1 demux after reset", demux_en, 0);
    rst_n = 1'b1;
    idle(2);

    // R3 sweep: window length x total relative to expected
    for (int w = 1; w <= 3; w++) begin
      for (int d = -1; d <= 1; d++) begin
        std_verified = 0; method_sel = 0; idle(2);
        check("R2 no lock while unverified", lock_o, 0);
        win_frames = 4'(w);
        exp_samples = 16'(4 + w);
        std_verified = 1; idle(1);
        frame_edge();
        audio_samples(4 + w + d);
        send_pkt(BAD_DID, 40, 11'd13, 12'd40, 1);   // R9 foreign DID
        send_pkt(AUD_DID, 40, 11'd13, 12'd90, 0);   // R10 invalid words
        send_pkt(AUD_DID, 0, 11'd14, 12'd40, 1);    // R9 zero samples
        for (int f = 0; f < w; f++) begin
          check("R3 no early lock", lock_o, 0);
          frame_edge();
        end
        check("R3 lock iff exact total", lock_o, (d == 0));
        check("R8 demux tracks lock", demux_en, (d == 0));
      end
    end

    // R6 / R7 sticky lock and release
    std_verified = 0; idle(2);
    win_frames = 2; exp_samples = 5;
    std_verified = 1; idle(1);
    frame_edge();
    audio_samples(5); frame_edge(); frame_edge();
    check("R3 lock with win 2", lock_o, 1);
    audio_samples(9); frame_edge(); frame_edge();
    check("R6 lock kept on surplus", lock_o, 1);
    audio_samples(1); frame_edge(); frame_edge();
    check("R6 lock kept on deficit", lock_o, 1);
    frame_edge();
    check("R7 lock held mid window", lock_o, 1);
    frame_edge();
    check("R7 lock released on empty window", lock_o, 0);
    check("R8 demux off after release", demux_en, 0);
    audio_samples(5); frame_edge(); frame_edge();
    check("R3 relock", lock_o, 1);
    std_verified = 0; idle(1);
    check("R2 verify drop clears lock", lock_o, 0);
    check("R8 demux off when unverified", demux_en, 0);

    // R4 / R5 control packet mode
    method_sel = 1; win_frames = 1; exp_samples = 3;
    std_verified = 1; idle(1);
    frame_edge();
    audio_samples(3); frame_edge();
    check("R5 audio alone gives no lock", lock_o, 0);
    frame_edge(); frame_edge();
    check("R5 empty stream no lock", lock_o, 0);
    send_pkt(CTL_DID, 4, 11'd9, 12'd21, 1);
    check("R4 wrong word position", lock_o, 0);
    send_pkt(CTL_DID, 4, 11'd10, 12'd20, 1);
    check("R4 wrong line", lock_o, 0);
    send_pkt(AUD_DID, 4, 11'd9, 12'd20, 1);
    check("R4 wrong DID", lock_o, 0);
    send_word(10'h000, 11'd9, 12'd20, 0, 1);
    send_word(10'h3FF, 11'd9, 12'd21, 0, 1);
    send_word(10'h200, 11'd9, 12'd22, 0, 1);
    send_word(CTL_DID, 11'd9, 12'd23, 0, 1);
    for (int k = 0; k < 8; k++) send_word(10'h004, 11'd9, 12'(24 + k), 0, 1);
    idle(3);
    check("R9 broken flag sequence ignored", lock_o, 0);
    send_pkt(CTL_DID, 4, 11'd9, 12'd20, 1);
    check("R4 correct control packet locks", lock_o, 1);
    check("R8 demux on", demux_en, 1);
    audio_samples(1); frame_edge();
    check("R6 control lock kept", lock_o, 1);
    frame_edge();
    check("R7 control lock released", lock_o, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule